// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches a running calendar, delivered as BCD fields, and raises an alarm interrupt when the time matches a programmed alarm. Six alarm fields are held in BCD: second, minute, hour, day of month, month and a three-digit year. Each field has its own match-enable bit, and a global enable gates the whole alarm. The timekeeping logic outside the block presents the current time together with a one-cycle strobe once each second, right after the time has advanced. The alarm is evaluated only on that strobe.

A match sets a sticky pending flag. The interrupt line is a level that follows this flag. Software clears the flag by writing a one to its bit. All alarm state is programmed and read through a simple single-cycle register port. The read data is combinational on the address. Register addresses: 0 control, 1 second, 2 minute, 3 hour, 4 day, 5 month, 6 year, 7 pending.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After a synchronous active-low reset, all alarm field registers, the control register and the pending flag read as zero, and `alarm_irq` is low.
- R2: Writes keep only each register's valid width: control 7 bits, second and minute 7 bits, hour and day 6 bits, month 5 bits, year 12 bits. Each register reads back the masked value.
- R3: Control bits 0 to 5 enable matching on second, minute, hour, day, month and year, in that order. The alarm fires only when every enabled field equals its current-time input, and a disabled field's mismatch has no effect.
- R4: With control bit 6 (global enable) clear, no alarm fires even when all enabled fields match.
- R5: With the global enable set and control bits 0 to 5 all clear, the alarm never fires.
- R6: Matching is evaluated only in a cycle where `sec_tick` is high. A matching time with no strobe does not fire. A fire shows on `alarm_irq` from the clock edge that samples the strobe.
- R7: The year is compared as 12 bits: the two low BCD digits in bits 7:0 and the hundreds digit in bits 11:8. A difference in the hundreds digit alone prevents a match.
- R8: A fire sets bit 1 of the pending register (read value 2). The flag stays set until it is cleared, and `alarm_irq` equals the flag.
- R9: Writing the pending register with bit 1 set clears the flag and drops `alarm_irq` from the next edge. Writing it with bit 1 clear has no effect. A fire in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| sec_tick | input | 1 | One-cycle strobe after the time advanced |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
Every register write and every strobe takes effect at the one rising edge that samples it, so a write, a fire or a clear is due exactly one edge after it is driven. Read data is due in the same cycle as the address. The bench drives on the falling edge and samples read data a moment after setting the address. It samples `alarm_irq` on the falling edge that follows the strobe or the write, and it checks the line again over later idle cycles to confirm that it is sticky and that a match with no strobe does not fire.

// File: rtl/bcd_alarm_pkg.sv
// Package: shared constants and types for the BCD alarm comparator.
// Assumes six alarm fields, each stored in a common 12-bit slot.
package bcd_alarm_pkg;
    localparam int NFIELD   = 6;
    localparam int FW       = 12;
    localparam int CTRL_W   = 7;
    localparam int GEN_BIT  = 6;
    localparam int PEND_BIT = 1;
    localparam int AW       = 3;

    localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADDR_PEND = 3'd7;

    typedef logic [NFIELD-1:0][FW-1:0] field_vec_t;

    // Valid-bit mask of each alarm field (0 sec .. 5 year)
    function automatic logic [FW-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 12'h07F;
            2, 3:    field_mask = 12'h03F;
            4:       field_mask = 12'h01F;
            default: field_mask = 12'hFFF;
        endcase
    endfunction

    // Register address that holds alarm field idx
    function automatic logic [AW-1:0] field_addr(input int idx);
        field_addr = AW'(idx + 1);
    endfunction
endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm register file. Holds the control register and the six
// masked alarm fields, and provides combinational read data that also
// shows the pending flag. Assumes DW >= FW and DW >= CTRL_W.
module alarm_regfile
    import bcd_alarm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              pend_q,
    output logic [DW-1:0]     reg_rdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output field_vec_t        alm_q
);
    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_we && reg_addr == ADDR_CTRL)
            ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    // One register per alarm field, masked to its width on write
    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[gi] <= '0;
            else if (reg_we && reg_addr == field_addr(gi))
                alm_q[gi] <= reg_wdata[FW-1:0] & field_mask(gi);
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_PEND: reg_rdata[PEND_BIT]   = pend_q;
            default:   reg_rdata[FW-1:0]     = alm_q[reg_addr - 3'd1];
        endcase
    end
endmodule

// File: rtl/alarm_match.sv
// Module: per-field BCD comparison. Produces a one-cycle fire pulse when
// the strobe is high, the global enable is set, at least one field is
// enabled and every enabled field equals the current time.
module alarm_match
    import bcd_alarm_pkg::*;
(
    input  logic              sec_tick,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  field_vec_t        alm_q,
    input  field_vec_t        now_q,
    output logic              fire
);
    logic [NFIELD-1:0] field_ok;

    // Each field passes when disabled or equal
    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_cmp
        assign field_ok[gi] = !ctrl_q[gi] || (alm_q[gi] == now_q[gi]);
    end

    // Combine strobe, global enable, non-empty mask and all field results
    always_comb begin
        fire = sec_tick && ctrl_q[GEN_BIT] && (|ctrl_q[NFIELD-1:0]) && (&field_ok);
    end
endmodule

// File: rtl/alarm_pending.sv
// Module: sticky pending flag. Set by a fire, cleared by a write of one
// to its bit. A fire wins over a clear in the same cycle.
module alarm_pending
    import bcd_alarm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          pend_q
);
    logic clr;

    // Decode the write-one-to-clear request
    assign clr = reg_we && reg_addr == ADDR_PEND && reg_wdata[PEND_BIT];

    // Hold, set or clear the flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (fire)
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/bcd_alarm_cmp.sv
// Module: top level of the BCD calendar alarm comparator. Packs the
// current-time inputs into field slots and connects the register file,
// the matcher and the pending flag. Assumes now_* are valid BCD and
// stable whenever sec_tick is high.
module bcd_alarm_cmp
    import bcd_alarm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sec_tick,
    input  logic [7:0]    now_sec,
    input  logic [7:0]    now_min,
    input  logic [7:0]    now_hour,
    input  logic [7:0]    now_day,
    input  logic [7:0]    now_mon,
    input  logic [11:0]   now_year,
    output logic          alarm_irq
);
    logic [CTRL_W-1:0] ctrl_q;
    field_vec_t        alm_q;
    field_vec_t        now_q;
    logic              fire;
    logic              pend_q;

    // Zero-extend the current-time fields into common slots
    always_comb begin
        now_q[0] = FW'(now_sec);
        now_q[1] = FW'(now_min);
        now_q[2] = FW'(now_hour);
        now_q[3] = FW'(now_day);
        now_q[4] = FW'(now_mon);
        now_q[5] = now_year;
    end

    alarm_regfile #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .reg_rdata (reg_rdata),
        .ctrl_q    (ctrl_q),
        .alm_q     (alm_q)
    );

    alarm_match u_match (
        .sec_tick (sec_tick),
        .ctrl_q   (ctrl_q),
        .alm_q    (alm_q),
        .now_q    (now_q),
        .fire     (fire)
    );

    alarm_pending #(.DW(DW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q)
    );

    assign alarm_irq = pend_q;
endmodule

// File: rtl/bcd_alarm_cmp_chk.sv
// Module: assertion checker for bcd_alarm_cmp, attached by bind. It
// relates the interrupt line to the strobe, the control register and
// register writes over one clock.
module bcd_alarm_cmp_chk
    import bcd_alarm_pkg::*;
#(
    parameter int DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              sec_tick,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              alarm_irq
);
    logic clr_req;
    assign clr_req = reg_we && reg_addr == ADDR_PEND && reg_wdata[PEND_BIT];

    AST_NO_FIRE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq && !sec_tick) |=> !alarm_irq); // R6
    AST_GLOBAL_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq && !ctrl_q[GEN_BIT]) |=> !alarm_irq); // R4
    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq && ctrl_q[NFIELD-1:0] == '0) |=> !alarm_irq); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && !clr_req) |=> alarm_irq); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && clr_req && !sec_tick) |=> !alarm_irq); // R9
endmodule

bind bcd_alarm_cmp bcd_alarm_cmp_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sec_tick  (sec_tick),
    .ctrl_q    (ctrl_q),
    .alarm_irq (alarm_irq)
);

// File: tb/bcd_alarm_cmp_tb.sv
// Directed bench for bcd_alarm_cmp: one task per scenario.
module bcd_alarm_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sec_tick = 1'b0;
    logic [7:0]  now_sec = '0, now_min = '0, now_hour = '0, now_day = '0, now_mon = '0;
    logic [11:0] now_year = '0;
    logic        alarm_irq;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    bcd_alarm_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_mon(now_mon), .now_year(now_year),
        .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_now(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] dy, input logic [7:0] mo, input logic [11:0] y);
        now_sec = s; now_min = mi; now_hour = h; now_day = dy; now_mon = mo; now_year = y;
    endtask

    // Strobe once; irq is sampled at the falling edge after the capturing edge
    task automatic tick;
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic clear_pend;
        wr(3'd7, 16'h0002);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 irq after reset", 16'(alarm_irq), 16'h0);
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1 register zero after reset", v, 16'h0);
        end
    endtask

    task automatic t_mask;
        logic [15:0] v;
        logic [15:0] exp [0:6];
        exp[0] = 16'h007F; exp[1] = 16'h007F; exp[2] = 16'h007F; exp[3] = 16'h003F;
        exp[4] = 16'h003F; exp[5] = 16'h001F; exp[6] = 16'h0FFF;
        for (int i = 0; i < 7; i++) begin
            wr(3'(i), 16'hFFFF);
            rd(3'(i), v);
            check("R2 write masked to field width", v, exp[i]);
            wr(3'(i), 16'h0000);
        end
    endtask

    task automatic t_second_only;
        logic [15:0] v;
        wr(3'd1, 16'h0030);
        wr(3'd0, 16'h0041);
        set_now(8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        repeat (4) @(negedge clk);
        check("R6 match without strobe stays silent", 16'(alarm_irq), 16'h0);
        set_now(8'h29, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        tick();
        check("R3 mismatched second no fire", 16'(alarm_irq), 16'h0);
        set_now(8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        tick();
        check("R6 fire right after strobe edge", 16'(alarm_irq), 16'h1);
        rd(3'd7, v);
        check("R8 pending bit 1 set", v, 16'h0002);
        repeat (3) @(negedge clk);
        check("R8 irq sticky", 16'(alarm_irq), 16'h1);
        wr(3'd7, 16'h0000);
        check("R9 write zero keeps flag", 16'(alarm_irq), 16'h1);
        clear_pend();
        check("R9 write one clears flag", 16'(alarm_irq), 16'h0);
        rd(3'd7, v);
        check("R9 pending reads zero after clear", v, 16'h0000);
    endtask

    task automatic t_all_fields;
        wr(3'd1, 16'h0045); wr(3'd2, 16'h0059); wr(3'd3, 16'h0023);
        wr(3'd4, 16'h0031); wr(3'd5, 16'h0012); wr(3'd6, 16'h0199);
        wr(3'd0, 16'h007F);
        set_now(8'h45, 8'h59, 8'h23, 8'h31, 8'h12, 12'h199);
        tick();
        check("R3 all six fields match fires", 16'(alarm_irq), 16'h1);
        clear_pend();
        set_now(8'h45, 8'h58, 8'h23, 8'h31, 8'h12, 12'h199);
        tick();
        check("R3 one enabled field off blocks fire", 16'(alarm_irq), 16'h0);
        wr(3'd0, 16'h007D);
        tick();
        check("R3 disabled minute mismatch ignored", 16'(alarm_irq), 16'h1);
        clear_pend();
    endtask

    task automatic t_global_off;
        wr(3'd0, 16'h003F);
        set_now(8'h45, 8'h59, 8'h23, 8'h31, 8'h12, 12'h199);
        tick();
        check("R4 global enable clear blocks fire", 16'(alarm_irq), 16'h0);
    endtask

    task automatic t_no_fields;
        wr(3'd0, 16'h0040);
        tick();
        check("R5 empty mask never fires", 16'(alarm_irq), 16'h0);
    endtask

    task automatic t_year;
        wr(3'd6, 16'h0123);
        wr(3'd0, 16'h0060);
        set_now(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 12'h023);
        tick();
        check("R7 hundreds digit differs no fire", 16'(alarm_irq), 16'h0);
        set_now(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 12'h124);
        tick();
        check("R7 low digits differ no fire", 16'(alarm_irq), 16'h0);
        set_now(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 12'h123);
        tick();
        check("R7 three-digit year match fires", 16'(alarm_irq), 16'h1);
    endtask

    task automatic t_set_beats_clear;
        // flag already set from t_year; strobe a match and clear together
        @(negedge clk);
        sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd7; reg_wdata = 16'h0002;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        check("R9 fire wins over clear", 16'(alarm_irq), 16'h1);
        clear_pend();
        check("R9 clear after collision", 16'(alarm_irq), 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_second_only();
        t_all_fields();
        t_global_off();
        t_no_fields();
        t_year();
        t_set_beats_clear();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule